// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

This block takes in one 32-bit word per frame from a serial data line. A slow serial bit clock times the line, and a frame-sync input marks the start of each frame. All logic runs on one fast system clock. The block turns the bit clock into a falling-edge strobe and does all of its sampling on that strobe. When it finds the start of a frame, it waits 0, 1 or 2 bit clocks, as the delay input selects. It then shifts in 32 bits, most significant first.

A finished word goes first into an internal holding buffer. On the next system clock it moves into the host data register, which raises a valid flag. The host pulses a read strobe to take the word. If a second word finishes while the host has not read the first, the first word stays and a sticky overrun flag is raised.

Top module: `fsync_rx`

## Requirements
- R1: A frame starts on the first bit-clock falling edge at which `fsync` is seen high after it was seen low at the previous falling edge.
- R2: With `dly` = 00, the first data bit (bit 31) is sampled on the same falling edge that detects the frame start.
- R3: With `dly` = 01 or 10, the first data bit is sampled 1 or 2 falling edges after the frame-start edge; code 11 behaves as 10.
- R4: Each frame delivers exactly 32 bits, shifted in most significant bit first, and yields one word.
- R5: The word leaves the shift register for the holding buffer on the system clock edge that samples the last bit. It moves on to `rdata` with `valid` high one system clock later.
- R6: Once `valid` is high, it stays high and `rdata` stays unchanged until `rd` is pulsed. `rd` clears `valid` on the next clock edge.
- R7: If a word completes while `valid` is high and `rd` is low, the word is dropped, `rdata` keeps the older word and `overrun` is set. `overrun` stays set until `rd` is pulsed.
- R8: A frame-sync edge that arrives during the delay wait or during the 32 data bits is ignored.
- R9: After reset, `valid` and `overrun` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock, synchronous to clk; data is sampled at its falling edge |
| fsync | input | 1 | Active-high frame sync |
| sdata | input | 1 | Serial data |
| dly | input | 2 | Data delay: 00 = 0, 01 = 1, 10 or 11 = 2 bit clocks |
| rd | input | 1 | Host read strobe, one clk cycle |
| rdata | output | 32 | Host data register |
| valid | output | 1 | rdata holds an unread word |
| overrun | output | 1 | A word was dropped because rdata was unread |

## Verification
If the delay counter is off by one, or the frame-start detection is wrong, every bit of the word shifts by one position. The error shows at `rdata` on the very next word that comes out, one system clock after its last bit. A wrong bit count makes `valid` rise early or late, which a check on the exact cycle catches. A frame sync that is wrongly accepted part way through a frame restarts the word and corrupts it. A wrong copy or overrun decision shows as a replaced word or a missing flag at the first read after two frames arrive back to back.

// File: rtl/fsync_rx.sv
module fsync_rx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsync,
  input  logic         sdata,
  input  logic [1:0]   dly,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         valid,
  output logic         overrun
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_t;

  st_t          st;
  logic         bclk_q, fs_prev, rbuf_full;
  logic [1:0]   rem;
  logic [CW-1:0] cnt;
  logic [W-1:0] sr, rbuf;

  wire       fall    = bclk_q & ~bclk;
  wire [1:0] dly_eff = (dly == 2'b11) ? 2'b10 : dly;
  wire       start   = fall && st == S_IDLE && fsync && !fs_prev;
  wire       sample  = fall && ((start && dly_eff == 2'd0) ||
                                (st == S_WAIT && rem == 2'd1) ||
                                st == S_SHIFT);
  wire       last    = fall && st == S_SHIFT && cnt == LAST;
  wire [W-1:0] sr_nx = {sr[W-2:0], sdata};
  wire       drop    = rbuf_full && valid && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (fall) fs_prev <= fsync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      rem <= 2'd0;
      cnt <= '0;
      sr  <= '0;
    end else begin
      if (sample) sr <= sr_nx;
      case (st)
        S_IDLE: if (start) begin
          if (dly_eff == 2'd0) begin
            st  <= S_SHIFT;
            cnt <= CW'(1);
          end else begin
            st  <= S_WAIT;
            rem <= dly_eff;
          end
        end
        S_WAIT: if (fall) begin
          if (rem == 2'd1) begin
            st  <= S_SHIFT;
            cnt <= CW'(1);
          end else rem <= rem - 2'd1;
        end
        S_SHIFT: if (fall) begin
          if (cnt == LAST) st <= S_IDLE;
          else cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf      <= '0;
      rbuf_full <= 1'b0;
      rdata     <= '0;
      valid     <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (last) begin
        rbuf      <= sr_nx;
        rbuf_full <= 1'b1;
      end else if (rbuf_full) rbuf_full <= 1'b0;

      if (rbuf_full && !drop) begin
        rdata <= rbuf;
        valid <= 1'b1;
      end else if (rd) valid <= 1'b0;

      if (drop) overrun <= 1'b1;
      else if (rd) overrun <= 1'b0;
    end
  end

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd) |=> valid); // R6
  AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd) |=> $stable(rdata)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rd) |=> overrun); // R7
  AST_VALID_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(rbuf_full)); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && cnt != LAST) |=> st == S_SHIFT); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R4
endmodule

// File: tb/fsync_rx_tb.sv
module fsync_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdata = 1'b0, rd = 1'b0;
  logic [1:0] dly = 2'b00;
  logic [31:0] rdata;
  logic valid, overrun;

  int checks = 0, errors = 0;
  bit auto_rd = 1'b0, done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  fsync_rx u_dut (.clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
                  .dly(dly), .rd(rd), .rdata(rdata), .valid(valid), .overrun(overrun));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic half(input logic b);
    @(negedge clk);
    bclk = b;
  endtask

  // xfs: extra frame-sync bit period (0 = none); lat: check R5 timing; push: expect word
  task automatic send(input logic [31:0] w, input logic [1:0] d, input int xfs,
                      input bit lat, input bit push, input string tag);
    int de;
    de = (d == 2'b11) ? 2 : d;
    dly = d;
    if (push) begin exp_q.push_back(w); tag_q.push_back(tag); end
    for (int p = 0; p < de + 32 + 3; p++) begin
      int b;
      b = p - de;
      half(1'b1);
      fsync = (p == 0) || (xfs != 0 && p == xfs);
      sdata = (b >= 0 && b < 32) ? w[31 - b] : ~w[31];
      repeat (3) @(negedge clk);
      half(1'b0);
      if (lat && p == de + 31) begin
        @(negedge clk);
        chk("R5 valid not yet", {31'd0, valid}, 32'd0);
        @(negedge clk);
        chk("R5 valid rises", {31'd0, valid}, 32'd1);
        repeat (1) @(negedge clk);
      end else repeat (3) @(negedge clk);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rd) rd = 1'b0;
      else if (auto_rd && valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: actual %h expected none (extra word)", rdata);
        end else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        rd = 1'b1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R9 valid", {31'd0, valid}, 32'd0);
    chk("R9 overrun", {31'd0, overrun}, 32'd0);
    chk("R9 rdata", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    auto_rd = 1'b1;
    send(32'hA5C3_0F81, 2'b00, 0, 1'b1, 1'b1, "R2 delay0");
    send(32'h1234_5678, 2'b01, 0, 1'b1, 1'b1, "R3 delay1");
    send(32'hF00D_CAFE, 2'b10, 0, 1'b1, 1'b1, "R3 delay2");
    send(32'h8000_0001, 2'b11, 0, 1'b0, 1'b1, "R3 code11");
    send(32'hFFFF_FFFF, 2'b00, 0, 1'b0, 1'b1, "R4 ones");
    send(32'h0000_0000, 2'b01, 0, 1'b0, 1'b1, "R4 zeros");
    send(32'h5555_AAAA, 2'b01, 12, 1'b0, 1'b1, "R8 fs mid-word");
    send(32'h3C3C_C3C3, 2'b10, 2, 1'b0, 1'b1, "R8 fs in delay");
    send(32'h7E81_1248, 2'b00, 31, 1'b0, 1'b1, "R1 fs last bit");
    repeat (20) @(negedge clk);
    chk("R6 valid cleared by rd", {31'd0, valid}, 32'd0);
    auto_rd = 1'b0;
    send(32'hDEAD_BEEF, 2'b01, 0, 1'b0, 1'b1, "R7 older kept");
    repeat (10) @(negedge clk);
    chk("R6 valid held unread", {31'd0, valid}, 32'd1);
    send(32'hBAD0_0BAD, 2'b01, 0, 1'b0, 1'b0, "R7 dropped");
    repeat (10) @(negedge clk);
    chk("R7 overrun set", {31'd0, overrun}, 32'd1);
    chk("R7 rdata keeps older", rdata, 32'hDEAD_BEEF);
    auto_rd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 overrun cleared", {31'd0, overrun}, 32'd0);
    chk("R6 valid cleared", {31'd0, valid}, 32'd0);
    send(32'h0F0F_1E1E, 2'b00, 0, 1'b1, 1'b1, "R1 after overrun");
    repeat (20) @(negedge clk);
    chk("R4 all words seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule